// File: doc/BRIEF.md
# Clock Output Enable and Stop Gating

This block sits between the internally generated CPU, SDRAM, PCI and AGP clocks and their output drivers. For each output clock it decides whether the clock runs or is held low. The decision combines a per-output "active" bit from the control registers, four active-low stop inputs (CPU stop, PCI stop, SDRAM stop and power-down), a free-running override for the third CPU-domain clock, and a latched mode strap. The strap decides whether the stop inputs exist at all. The block also produces a single output-enable that a global tristate bit clears.

Every enable is re-timed into its own clock domain. The stop inputs pass through a synchronizer of `SYNC_STAGES` flip-flops clocked by the domain clock. The final enable register is clocked on the falling edge of that clock, so an output can only start or stop while its clock is low, and every high pulse it emits has full width. When the strap is high, four of the SDRAM outputs are given up as stop/power-down input pins and are held low.

Top module: `clkout_gate`

## Requirements
- R1: While `rst_n` is low every clock output is low. After release, the first falling edge of each source clock loads its enables, so with all active bits set and no stop asserted each output follows its source from the next high phase.
- R2: Active bits (1 = run) map as follows. CPU0, CPU1 and CPU2 come from `ctl_cpu` bits 0, 1 and 2. SDRAM11 comes from `ctl_cpu` bit 6 and SDRAM12 from `ctl_cpu` bit 3. SDRAM0..7 come from `ctl_sdram_lo` bits 0..7 and SDRAM8..10 from `ctl_sdram_hi` bits 0..2. PCI0..5 come from `ctl_pci` bits 0..5, and AGP0..1 from `ctl_pci` bits 6..7.
- R3: A change of an active bit made while the clock is low takes effect at the next falling edge. The output is therefore unchanged in the next high phase and follows the new bit from the high phase after that. No high phase is ever cut short.
- R4: `out_en` is the inverse of `ctl_mode` bit 0 and follows it without a clock. The other bits of `ctl_mode` have no effect on any output.
- R5: With `strap_mode` = 0 all four stop inputs are ignored, and SDRAM8..11 behave as ordinary clock outputs.
- R6: With `strap_mode` = 1, SDRAM8..11 are held low whatever their active bits.
- R7: With `strap_mode` = 1, `stop_cpu_n` low stops CPU0 and CPU1.
- R8: CPU2 is stopped by `stop_cpu_n` only when `ctl_cpu` bit 7 is 1. When that bit is 0, CPU2 runs freely regardless of `stop_cpu_n`.
- R9: With `strap_mode` = 1, `stop_pci_n` low stops all PCI outputs and `stop_sdram_n` low stops all SDRAM outputs. Neither touches the CPU or AGP outputs.
- R10: With `strap_mode` = 1, `pwrdn_n` low stops every clock output in all four domains.
- R11: A stop input level first sampled at rising edge P0 of a domain clock shows at that domain's outputs from the high phase that begins at rising edge P(SYNC_STAGES). Asserting and releasing a stop have the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cpu_src | input | 1 | Ungated CPU-domain clock |
| clk_sdram_src | input | 1 | Ungated SDRAM-domain clock |
| clk_pci_src | input | 1 | Ungated PCI-domain clock |
| clk_agp_src | input | 1 | Ungated AGP-domain clock |
| ctl_mode | input | 8 | Mode byte; bit 0 = tristate all outputs |
| ctl_cpu | input | 8 | CPU active bits, SDRAM11/12 active bits, bit 7 = CPU2 stoppable |
| ctl_pci | input | 8 | PCI0..5 and AGP0..1 active bits |
| ctl_sdram_lo | input | 8 | SDRAM0..7 active bits |
| ctl_sdram_hi | input | 8 | Bits 2..0 = SDRAM10..8 active bits |
| strap_mode | input | 1 | Latched strap; 1 = four SDRAM pins serve as stop inputs |
| stop_cpu_n | input | 1 | Asynchronous CPU clock stop, active low |
| stop_pci_n | input | 1 | Asynchronous PCI clock stop, active low |
| stop_sdram_n | input | 1 | Asynchronous SDRAM clock stop, active low |
| pwrdn_n | input | 1 | Asynchronous power-down, active low |
| clk_cpu_o | output | 3 | Gated CPU0..2 clocks |
| clk_sdram_o | output | 13 | Gated SDRAM0..12 clocks |
| clk_pci_o | output | 6 | Gated PCI0..5 clocks |
| clk_agp_o | output | 2 | Gated AGP0..1 clocks |
| out_en | output | 1 | Output-driver enable, low = tristate |

## Verification
The stop inputs take effect SYNC_STAGES rising edges after the edge that first samples them, while register bits take effect at the first falling edge after they change. Both therefore first show in a high phase, and `out_en` responds at once. The bench drives all inputs one nanosecond after a falling edge. It samples two nanoseconds into every high phase against a reference enable that it recomputes at each falling edge from a delay queue of sampled stop levels. It samples two nanoseconds into every low phase expecting all clocks low. The targeted latency checks count the rising edges explicitly from the edge that first sees a new level.

// File: rtl/clkout_gate_pkg.sv
`timescale 1ns/1ps
package clkout_gate_pkg;
   // output counts per clock domain
   localparam int CPU_N   = 3;
   localparam int SDRAM_N = 13;
   localparam int PCI_N   = 6;
   localparam int AGP_N   = 2;
   // SDRAM outputs given up as input pins when the strap is set
   localparam int PIN_LO  = 8;
   localparam int PIN_HI  = 11;
   // stop vector layout inside a bank
   localparam int STP_GRP = 0;
   localparam int STP_PD  = 1;
   localparam int STP_N   = 2;
   // index of the CPU output that may free-run
   localparam int CPU_FREE = 2;
endpackage

// File: rtl/clkout_gate_sync.sv
`timescale 1ns/1ps
module clkout_gate_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("clkout_gate_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkout_gate_bank.sv
`timescale 1ns/1ps
module clkout_gate_bank #(
   parameter int NOUT   = 4,
   parameter int NSTOP  = 2,
   parameter int STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NOUT-1:0]             run_req,
   input  logic [NSTOP-1:0]            stop_n_raw,
   input  logic [NOUT-1:0][NSTOP-1:0]  stop_use,
   output logic [NOUT-1:0]             clk_out
);
   generate
      if (NOUT < 1 || NSTOP < 1) begin : g_bad
         $error("clkout_gate_bank: NOUT and NSTOP must be positive");
      end
   endgenerate

   logic [NSTOP-1:0] stop_n_s;
   logic [NOUT-1:0]  en_d;
   logic [NOUT-1:0]  en_q;

   genvar s;
   generate
      for (s = 0; s < NSTOP; s++) begin : g_sync
         clkout_gate_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (stop_n_raw[s]),
            .q     (stop_n_s[s])
         );
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < NOUT; i++) begin
         en_d[i] = run_req[i] & ~|(stop_use[i] & ~stop_n_s);
      end
   end

   // enables move only on the falling edge, while the clock is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   genvar o;
   generate
      for (o = 0; o < NOUT; o++) begin : g_gate
         assign clk_out[o] = clk & en_q[o];
      end
   endgenerate
endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/1ps
module clkout_gate
   import clkout_gate_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                rst_n,
   input  logic                clk_cpu_src,
   input  logic                clk_sdram_src,
   input  logic                clk_pci_src,
   input  logic                clk_agp_src,
   input  logic [7:0]          ctl_mode,
   input  logic [7:0]          ctl_cpu,
   input  logic [7:0]          ctl_pci,
   input  logic [7:0]          ctl_sdram_lo,
   input  logic [7:0]          ctl_sdram_hi,
   input  logic                strap_mode,
   input  logic                stop_cpu_n,
   input  logic                stop_pci_n,
   input  logic                stop_sdram_n,
   input  logic                pwrdn_n,
   output logic [CPU_N-1:0]    clk_cpu_o,
   output logic [SDRAM_N-1:0]  clk_sdram_o,
   output logic [PCI_N-1:0]    clk_pci_o,
   output logic [AGP_N-1:0]    clk_agp_o,
   output logic                out_en
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("clkout_gate: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic unused_ctl;
   assign unused_ctl = ^{ctl_mode[7:1], ctl_cpu[5:4], ctl_sdram_hi[7:3]};

   assign out_en = ~ctl_mode[0];

   // ---------------- run requests from the active bits
   logic [CPU_N-1:0]   cpu_run;
   logic [SDRAM_N-1:0] sdram_raw;
   logic [SDRAM_N-1:0] sdram_run;
   logic [PCI_N-1:0]   pci_run;
   logic [AGP_N-1:0]   agp_run;

   assign cpu_run   = ctl_cpu[CPU_N-1:0];
   assign sdram_raw = {ctl_cpu[3], ctl_cpu[6], ctl_sdram_hi[2:0], ctl_sdram_lo};
   assign pci_run   = ctl_pci[PCI_N-1:0];
   assign agp_run   = ctl_pci[PCI_N +: AGP_N];

   genvar k;
   generate
      for (k = 0; k < SDRAM_N; k++) begin : g_sdram_run
         if (k >= PIN_LO && k <= PIN_HI) begin : g_pin
            assign sdram_run[k] = sdram_raw[k] & ~strap_mode;
         end else begin : g_clk
            assign sdram_run[k] = sdram_raw[k];
         end
      end
   endgenerate

   // ---------------- which stops each output obeys
   logic [CPU_N-1:0][STP_N-1:0]   cpu_use;
   logic [SDRAM_N-1:0][STP_N-1:0] sdram_use;
   logic [PCI_N-1:0][STP_N-1:0]   pci_use;
   logic [AGP_N-1:0][0:0]         agp_use;

   generate
      for (k = 0; k < CPU_N; k++) begin : g_cpu_use
         assign cpu_use[k][STP_PD] = strap_mode;
         if (k == CPU_FREE) begin : g_free
            assign cpu_use[k][STP_GRP] = strap_mode & ctl_cpu[7];
         end else begin : g_fixed
            assign cpu_use[k][STP_GRP] = strap_mode;
         end
      end
      for (k = 0; k < SDRAM_N; k++) begin : g_sdram_use
         assign sdram_use[k] = {STP_N{strap_mode}};
      end
      for (k = 0; k < PCI_N; k++) begin : g_pci_use
         assign pci_use[k] = {STP_N{strap_mode}};
      end
      for (k = 0; k < AGP_N; k++) begin : g_agp_use
         assign agp_use[k] = strap_mode;
      end
   endgenerate

   // ---------------- stop vectors (group stop, power-down)
   logic [STP_N-1:0] cpu_stops, sdram_stops, pci_stops;
   assign cpu_stops   = {pwrdn_n, stop_cpu_n};
   assign sdram_stops = {pwrdn_n, stop_sdram_n};
   assign pci_stops   = {pwrdn_n, stop_pci_n};

   clkout_gate_bank #(.NOUT(CPU_N), .NSTOP(STP_N), .STAGES(SYNC_STAGES)) u_cpu (
      .clk        (clk_cpu_src),
      .rst_n      (rst_n),
      .run_req    (cpu_run),
      .stop_n_raw (cpu_stops),
      .stop_use   (cpu_use),
      .clk_out    (clk_cpu_o)
   );

   clkout_gate_bank #(.NOUT(SDRAM_N), .NSTOP(STP_N), .STAGES(SYNC_STAGES)) u_sdram (
      .clk        (clk_sdram_src),
      .rst_n      (rst_n),
      .run_req    (sdram_run),
      .stop_n_raw (sdram_stops),
      .stop_use   (sdram_use),
      .clk_out    (clk_sdram_o)
   );

   clkout_gate_bank #(.NOUT(PCI_N), .NSTOP(STP_N), .STAGES(SYNC_STAGES)) u_pci (
      .clk        (clk_pci_src),
      .rst_n      (rst_n),
      .run_req    (pci_run),
      .stop_n_raw (pci_stops),
      .stop_use   (pci_use),
      .clk_out    (clk_pci_o)
   );

   clkout_gate_bank #(.NOUT(AGP_N), .NSTOP(1), .STAGES(SYNC_STAGES)) u_agp (
      .clk        (clk_agp_src),
      .rst_n      (rst_n),
      .run_req    (agp_run),
      .stop_n_raw (pwrdn_n),
      .stop_use   (agp_use),
      .clk_out    (clk_agp_o)
   );
endmodule

// File: rtl/clkout_gate_chk.sv
`timescale 1ns/1ps
module clkout_gate_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic        rst_n,
   input logic        clk_cpu_src,
   input logic        clk_sdram_src,
   input logic        clk_pci_src,
   input logic        clk_agp_src,
   input logic [7:0]  ctl_pci,
   input logic        strap_mode,
   input logic        stop_cpu_n,
   input logic        pwrdn_n,
   input logic [2:0]  clk_cpu_o,
   input logic [12:0] clk_sdram_o,
   input logic [5:0]  clk_pci_o,
   input logic [1:0]  clk_agp_o
);
   localparam int LIM = SYNC_STAGES + 1;
   localparam int CW  = $clog2(LIM + 1) + 1;

   // consecutive rising edges that saw the stop asserted, saturating
   logic [CW-1:0] n_pd_cpu, n_cs_cpu, n_pd_agp;

   always_ff @(posedge clk_cpu_src or negedge rst_n) begin
      if (!rst_n) begin
         n_pd_cpu <= '0;
         n_cs_cpu <= '0;
      end else begin
         if (strap_mode && !pwrdn_n) begin
            if (n_pd_cpu != CW'(LIM)) n_pd_cpu <= n_pd_cpu + 1'b1;
         end else n_pd_cpu <= '0;
         if (strap_mode && !stop_cpu_n) begin
            if (n_cs_cpu != CW'(LIM)) n_cs_cpu <= n_cs_cpu + 1'b1;
         end else n_cs_cpu <= '0;
      end
   end

   always_ff @(posedge clk_agp_src or negedge rst_n) begin
      if (!rst_n) n_pd_agp <= '0;
      else if (strap_mode && !pwrdn_n) begin
         if (n_pd_agp != CW'(LIM)) n_pd_agp <= n_pd_agp + 1'b1;
      end else n_pd_agp <= '0;
   end

   // sampled at the falling edge, outputs show their high-phase value
   a_r10_pd_cpu: assert property (@(negedge clk_cpu_src) disable iff (!rst_n)
      (n_pd_cpu == CW'(LIM)) |-> (clk_cpu_o == '0));

   a_r10_pd_agp: assert property (@(negedge clk_agp_src) disable iff (!rst_n)
      (n_pd_agp == CW'(LIM)) |-> (clk_agp_o == '0));

   a_r7_cpu_stop: assert property (@(negedge clk_cpu_src) disable iff (!rst_n)
      (n_cs_cpu == CW'(LIM)) |-> (clk_cpu_o[1:0] == 2'b00));

   a_r6_strap_pins: assert property (@(negedge clk_sdram_src) disable iff (!rst_n)
      (strap_mode && $past(strap_mode)) |-> (clk_sdram_o[11:8] == 4'b0000));

   a_r2_pci_inactive: assert property (@(negedge clk_pci_src) disable iff (!rst_n)
      ((clk_pci_o & ~ctl_pci[5:0] & ~$past(ctl_pci[5:0])) == 6'b0));
endmodule

bind clkout_gate clkout_gate_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/test_clkout_gate.sv
`timescale 1ns/1ps
module test_clkout_gate;
   localparam int S = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic [7:0]  r_ctl, r_cpu, r_pci, r_slo, r_shi;
   logic        strap, cs_n, ps_n, ss_n, pd_n;
   logic [2:0]  o_cpu;
   logic [12:0] o_sd;
   logic [5:0]  o_pci;
   logic [1:0]  o_agp;
   logic        o_en;

   int    n_chk = 0;
   int    n_err = 0;
   string cur_req = "R1";
   bit    done = 0;

   clkout_gate i_clkout_gate (
      .rst_n(rst_n), .clk_cpu_src(clk), .clk_sdram_src(clk), .clk_pci_src(clk),
      .clk_agp_src(clk), .ctl_mode(r_ctl), .ctl_cpu(r_cpu), .ctl_pci(r_pci),
      .ctl_sdram_lo(r_slo), .ctl_sdram_hi(r_shi), .strap_mode(strap),
      .stop_cpu_n(cs_n), .stop_pci_n(ps_n), .stop_sdram_n(ss_n), .pwrdn_n(pd_n),
      .clk_cpu_o(o_cpu), .clk_sdram_o(o_sd), .clk_pci_o(o_pci), .clk_agp_o(o_agp),
      .out_en(o_en)
   );

   // ---------------- reference model
   bit q_cs[$], q_ps[$], q_ss[$], q_pd[$];
   logic [23:0] exp_en = '0;

   function automatic logic [23:0] ref_en();
      bit pd_on = strap && !q_pd[S-1];
      bit cs_on = strap && !q_cs[S-1];
      bit ps_on = strap && !q_ps[S-1];
      bit ss_on = strap && !q_ss[S-1];
      logic [2:0]  c;
      logic [12:0] s;
      logic [5:0]  p;
      logic [1:0]  a;
      c[0] = r_cpu[0] && !pd_on && !cs_on;
      c[1] = r_cpu[1] && !pd_on && !cs_on;
      c[2] = r_cpu[2] && !pd_on && !(cs_on && r_cpu[7]);
      s = {r_cpu[3], r_cpu[6], r_shi[2:0], r_slo};
      if (strap) s[11:8] = 4'b0;
      if (pd_on || ss_on) s = '0;
      p = r_pci[5:0];
      if (pd_on || ps_on) p = '0;
      a = r_pci[7:6];
      if (pd_on) a = '0;
      return {c, s, p, a};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q_cs = {}; q_ps = {}; q_ss = {}; q_pd = {};
         for (int i = 0; i < S; i++) begin
            q_cs.push_back(1'b1); q_ps.push_back(1'b1);
            q_ss.push_back(1'b1); q_pd.push_back(1'b1);
         end
      end else begin
         q_cs.push_front(cs_n); void'(q_cs.pop_back());
         q_ps.push_front(ps_n); void'(q_ps.pop_back());
         q_ss.push_front(ss_n); void'(q_ss.pop_back());
         q_pd.push_front(pd_n); void'(q_pd.pop_back());
      end
   end

   always @(negedge clk) begin
      if (!rst_n) exp_en = '0;
      else        exp_en = ref_en();
   end

   // ---------------- checking
   task automatic want(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp(bit hi);
      logic [23:0] act = {o_cpu, o_sd, o_pci, o_agp};
      want(cur_req, {8'h0, act}, {8'h0, hi ? exp_en : 24'h0});
      want("R4", {31'h0, o_en}, {31'h0, ~r_ctl[0]});
   endtask

   initial begin
      #1;
      forever begin
         @(posedge clk); #2; if (!done) cmp(1'b1);
         @(negedge clk); #2; if (!done) cmp(1'b0);
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic at_high();
      @(posedge clk); #2;
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   // ---------------- stimulus
   logic [15:0] lfsr = 16'hACE1;

   initial begin
      rst_n = 0; r_ctl = 8'h00; r_cpu = 8'hCF; r_pci = 8'hFF;
      r_slo = 8'hFF; r_shi = 8'h07; strap = 0;
      cs_n = 1; ps_n = 1; ss_n = 1; pd_n = 1;
      tick(4);
      at_high();
      want("R1 reset low", {8'h0, o_cpu, o_sd, o_pci, o_agp}, 32'h0);
      tick(1);
      rst_n = 1;
      at_high();
      want("R1 before first fall", {8'h0, o_cpu, o_sd, o_pci, o_agp}, 32'h0);
      at_high();
      want("R1 running", {8'h0, o_cpu, o_sd, o_pci, o_agp}, 32'h00FF_FFFF);

      // R2 bit mapping
      tick(1);
      cur_req = "R2";
      r_cpu = 8'hC5; r_pci = 8'h96; r_slo = 8'h3C; r_shi = 8'h05;
      tick(3);
      at_high();
      want("R2 cpu", {29'h0, o_cpu}, 32'h5);
      want("R2 sdram", {19'h0, o_sd}, {19'h0, 1'b0, 1'b1, 3'b101, 8'h3C});
      want("R2 pci", {26'h0, o_pci}, 32'h16);
      want("R2 agp", {30'h0, o_agp}, 32'h2);
      tick(1);
      r_cpu = 8'h3A; r_pci = 8'h69; r_slo = 8'hC3; r_shi = 8'hFA;
      tick(4);
      r_cpu = 8'hCF; r_pci = 8'hFF; r_slo = 8'hFF; r_shi = 8'h07;
      tick(3);

      // R4 tristate
      cur_req = "R4";
      r_ctl = 8'h01;
      #1 want("R4 tristate", {31'h0, o_en}, 32'h0);
      tick(2);
      at_high();
      want("R4 clocks unaffected", {29'h0, o_cpu}, 32'h7);
      tick(1);
      r_ctl = 8'hFE;
      #1 want("R4 other bits ignored", {31'h0, o_en}, 32'h1);
      tick(2);
      r_ctl = 8'h00;

      // R5 stops ignored without strap
      cur_req = "R5";
      cs_n = 0; ps_n = 0; ss_n = 0; pd_n = 0;
      tick(6);
      at_high();
      want("R5 all running", {8'h0, o_cpu, o_sd, o_pci, o_agp}, 32'h00FF_FFFF);
      tick(1);
      cs_n = 1; ps_n = 1; ss_n = 1; pd_n = 1;
      tick(2);

      // R6 strap takes the four pins
      cur_req = "R6";
      strap = 1; r_shi = 8'hFF;
      tick(3);
      at_high();
      want("R6 pins low", {28'h0, o_sd[11:8]}, 32'h0);
      want("R6 others run", {24'h0, o_sd[7:0]}, 32'hFF);

      // R7 / R11 cpu stop latency
      tick(1);
      cur_req = "R7";
      cs_n = 0;
      at_high(); want("R11 edge P0", {29'h0, o_cpu}, 32'h7);
      at_high(); want("R11 edge P1", {29'h0, o_cpu}, 32'h7);
      at_high(); want("R7 R11 stopped at P2", {29'h0, o_cpu}, 32'h0);
      want("R9 agp untouched by cpu stop", {30'h0, o_agp}, 32'h3);

      // R8 free-running third clock
      tick(1);
      cur_req = "R8";
      r_cpu = 8'h4F;
      at_high(); want("R8 next high unchanged", {29'h0, o_cpu}, 32'h0);
      at_high(); want("R8 free running", {29'h0, o_cpu}, 32'h4);
      tick(1);
      cs_n = 1;
      at_high(); want("R11 release P0", {29'h0, o_cpu}, 32'h4);
      at_high(); want("R11 release P1", {29'h0, o_cpu}, 32'h4);
      at_high(); want("R11 release P2", {29'h0, o_cpu}, 32'h7);
      tick(1);
      r_cpu = 8'hCF;

      // R9 group stops
      cur_req = "R9";
      ps_n = 0;
      tick(4);
      at_high();
      want("R9 pci stopped", {26'h0, o_pci}, 32'h0);
      want("R9 sdram runs", {19'h0, o_sd}, 32'h10FF);
      tick(1);
      ps_n = 1; ss_n = 0;
      tick(4);
      at_high();
      want("R9 sdram stopped", {19'h0, o_sd}, 32'h0);
      want("R9 pci back", {26'h0, o_pci}, 32'h3F);
      want("R9 cpu untouched", {29'h0, o_cpu}, 32'h7);
      tick(1);
      ss_n = 1;

      // R10 power-down
      cur_req = "R10";
      pd_n = 0;
      tick(4);
      at_high();
      want("R10 all stopped", {8'h0, o_cpu, o_sd, o_pci, o_agp}, 32'h0);
      tick(1);
      pd_n = 1;
      tick(4);

      // R3 register change timing
      cur_req = "R3";
      r_pci = 8'hFE;
      at_high(); want("R3 next high unchanged", {31'h0, o_pci[0]}, 32'h1);
      at_high(); want("R3 stopped after fall", {31'h0, o_pci[0]}, 32'h0);
      tick(1);
      r_pci = 8'hFF;

      // mixed patterns
      cur_req = "R2,R9,R10,R11";
      for (int i = 0; i < 1500; i++) begin
         tick(1);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cs_n = lfsr[0] | lfsr[1];
         ps_n = lfsr[2] | lfsr[3];
         ss_n = lfsr[4] | lfsr[5];
         pd_n = lfsr[6] | lfsr[7] | lfsr[8];
         if (lfsr[10:8] == 3'd1) r_cpu = lfsr[15:8] ^ lfsr[7:0];
         if (lfsr[11:9] == 3'd5) r_pci = lfsr[7:0];
         if (lfsr[12:10] == 3'd3) r_slo = lfsr[15:8];
         if (lfsr[13:11] == 3'd6) r_shi = lfsr[7:0];
         strap = (i < 1200);
      end
      tick(4);
      finish_run();
   end
endmodule